// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs whole block-erase and page-program operations on an asynchronous NAND flash bus. A host gives one request with the operation, the index of the chip-enable line to use, a row address and (for program) a column address. For a program it then streams items: data bytes, column-change markers that carry a new column, and a closing marker. The block turns all of this into command, address and data bus cycles, strobed with WE#. CLE marks command cycles and ALE marks address cycles.

After the confirm command the block waits a fixed guard time so that the device can pull the shared open-drain ready/busy line low. It then waits for that line to go high again. Next it issues a status-read command, pulses RE# once and captures the byte the device returns. A one-cycle done pulse then reports that byte, with bit 0 as the fail flag.

Top module: `nand_op_seq`

## Requirements
- R1: An erase (req_op=0) sends command 0x60, then the three row bytes least significant first, then command 0xD0. All row bits are sent unchanged, including the bits that select a page inside a block.
- R2: A program (req_op=1) sends command 0x80, column low byte, column high byte, the three row bytes least significant first, then one data cycle for each data item (wr_kind=0, byte in wr_data[7:0]). A closing item (wr_kind=2) sends command 0x10.
- R3: A column-change item (wr_kind=1) sends command 0x85 and then the two bytes of wr_data[15:0], low byte first. Data items that follow continue the stream. An item with wr_kind=3 is consumed and produces no bus cycle.
- R4: CLE is high only in command cycles and ALE only in address cycles. Both are low in data cycles. Each write cycle holds WE# low for T_LO clocks, and CLE, ALE and dq_out are valid at the rising edge of WE#.
- R5: From the accepted request until done, ce_n[req_cs] is low and every other ce_n bit is high. While idle all ce_n bits are high.
- R6: After the confirm command the block waits GUARD_CYC clocks and then until the synchronised rb_n reads high. Only then does it send the status command.
- R7: The status read is command 0x70 followed by exactly one RE# pulse. The byte on dq_in is captured as RE# rises. A one-cycle done pulse presents it on status, with fail equal to status bit 0.
- R8: dq_oe is high during every WE# low phase and low whenever RE# is low.
- R9: After reset ce_n is all ones, WE# and RE# are high, dq_oe is low, done is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 1 | 0 = block erase, 1 = page program |
| req_cs | input | 2 | Index of the chip-enable line to drive |
| req_row | input | 24 | Row (page) address |
| req_col | input | 16 | Starting column for program |
| wr_valid | input | 1 | Program stream item valid |
| wr_ready | output | 1 | Program stream item accepted this cycle when valid |
| wr_kind | input | 2 | 0 data, 1 column change, 2 close, 3 discarded |
| wr_data | input | 16 | Data byte in [7:0], or new column |
| ce_n | output | 4 | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| dq_out | output | 8 | Bus value driven to the device |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 8 | Bus value read from the device |
| rb_n | input | 1 | Shared ready/busy, low while busy |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Captured status byte, valid with done |
| fail | output | 1 | Status bit 0, valid with done |

## Verification
The bench feeds an erase whose page-select row bits are non-zero. A design that masks those bits would send different row bytes. Program streams carry two column changes and a discarded item: a design that dropped the 0x85 segment, swapped the column byte order or emitted a cycle for the discarded kind would break the expected cycle order. The bench's ready/busy model pulls the line low only two clocks after the confirm, so a design with no guard wait would read status before the device finished and report done early. A final erase returns a status with bit 0 set, which catches a design with an inverted or wrongly placed fail flag.

// File: rtl/nand_seq_pkg.sv
// Package: shared cycle kinds, stream item kinds and command opcodes of the
// NAND operation sequencer.
package nand_seq_pkg;
    typedef enum logic [1:0] {CYC_CMD, CYC_ADR, CYC_DAT, CYC_RD} cyc_kind_t;

    localparam logic [1:0] WK_DATA   = 2'd0;
    localparam logic [1:0] WK_COLCHG = 2'd1;
    localparam logic [1:0] WK_END    = 2'd2;

    localparam logic [7:0] OPC_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OPC_ERASE_CONF  = 8'hD0;
    localparam logic [7:0] OPC_PROG_SETUP  = 8'h80;
    localparam logic [7:0] OPC_PROG_CONF   = 8'h10;
    localparam logic [7:0] OPC_COL_CHANGE  = 8'h85;
    localparam logic [7:0] OPC_STATUS      = 8'h70;
endpackage

// File: rtl/nand_cyc_engine.sv
// Bus cycle engine: runs one command, address, data-write or read cycle per
// start pulse. The strobe is held low for T_LO clocks and high for T_HI clocks.
// CLE, ALE and dq_out stay steady over the whole cycle.
// Assumes T_LO, T_HI >= 1 and that start comes only while busy is low.
module nand_cyc_engine
    import nand_seq_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  cyc_kind_t kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic      busy,
    output logic      cyc_done,
    output logic [7:0] rd_byte,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic [7:0] dq_out,
    output logic      dq_oe
);
    localparam int TMAX  = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int CNT_W = $clog2(TMAX + 1);

    logic             hi_ph;
    logic [CNT_W-1:0] cnt;
    cyc_kind_t        kind_q;
    logic [7:0]       byte_q;

    // Cycle phase sequencing and read capture at the end of the low phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            hi_ph   <= 1'b0;
            cnt     <= '0;
            kind_q  <= CYC_CMD;
            byte_q  <= '0;
            rd_byte <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                hi_ph  <= 1'b0;
                cnt    <= CNT_W'(T_LO - 1);
                kind_q <= kind;
                byte_q <= wbyte;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (!hi_ph) begin
            hi_ph <= 1'b1;
            cnt   <= CNT_W'(T_HI - 1);
            if (kind_q == CYC_RD) rd_byte <= dq_in;
        end else begin
            busy <= 1'b0;
        end
    end

    // Pin decode from the held cycle state
    always_comb begin
        cyc_done = busy && hi_ph && (cnt == '0);
        we_n     = !(busy && !hi_ph && (kind_q != CYC_RD));
        re_n     = !(busy && !hi_ph && (kind_q == CYC_RD));
        cle      = busy && (kind_q == CYC_CMD);
        ale      = busy && (kind_q == CYC_ADR);
        dq_oe    = busy && (kind_q != CYC_RD);
        dq_out   = byte_q;
    end
endmodule

// File: rtl/nand_op_ctrl.sv
// Operation controller: walks the erase or program sequence, the program
// stream, the guard wait, the ready/busy wait and the status read. It asks the
// cycle engine for one bus cycle at a time. Assumes NCE >= 2, GUARD_CYC >= 1
// and rb_ready already synchronised to clk.
module nand_op_ctrl
    import nand_seq_pkg::*;
#(
    parameter int NCE       = 4,
    parameter int ROW_BYTES = 3,
    parameter int COL_BYTES = 2,
    parameter int GUARD_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_op,
    input  logic [$clog2(NCE)-1:0]   req_cs,
    input  logic [ROW_BYTES*8-1:0]   req_row,
    input  logic [COL_BYTES*8-1:0]   req_col,
    input  logic                     wr_valid,
    output logic                     wr_ready,
    input  logic [1:0]               wr_kind,
    input  logic [COL_BYTES*8-1:0]   wr_data,
    input  logic                     eng_busy,
    input  logic                     eng_done,
    input  logic [7:0]               eng_rd,
    input  logic                     rb_ready,
    output logic                     eng_start,
    output cyc_kind_t                eng_kind,
    output logic [7:0]               eng_byte,
    output logic [NCE-1:0]           ce_n,
    output logic                     done,
    output logic [7:0]               status,
    output logic                     fail
);
    localparam int CS_W  = $clog2(NCE);
    localparam int ROW_W = ROW_BYTES * 8;
    localparam int COL_W = COL_BYTES * 8;
    localparam int ADR_W = ROW_W + COL_W;
    localparam int LEFT_W = $clog2(ROW_BYTES + COL_BYTES + 1);
    localparam int G_W   = $clog2(GUARD_CYC + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADR, S_STRM, S_CCMD, S_CONF,
        S_GUARD, S_RB, S_SCMD, S_SRD, S_DONE
    } st_t;

    st_t              st;
    logic             is_prog;
    logic [CS_W-1:0]  cs_q;
    logic [ADR_W-1:0] adr_sr;
    logic [LEFT_W-1:0] adr_left;
    logic             wait_q;
    logic [G_W-1:0]   gcnt;
    logic [7:0]       status_q;
    logic             free;
    logic             wr_fire;

    // Cycle requests to the engine and stream handshake
    always_comb begin
        free      = !wait_q && !eng_busy;
        wr_ready  = (st == S_STRM) && free;
        wr_fire   = wr_valid && wr_ready;
        eng_start = 1'b0;
        eng_kind  = CYC_CMD;
        eng_byte  = '0;
        case (st)
            S_CMD:  begin eng_start = free; eng_byte = is_prog ? OPC_PROG_SETUP : OPC_ERASE_SETUP; end
            S_ADR:  begin eng_start = free; eng_kind = CYC_ADR; eng_byte = adr_sr[7:0]; end
            S_STRM: begin
                eng_start = wr_fire && (wr_kind == WK_DATA);
                eng_kind  = CYC_DAT;
                eng_byte  = wr_data[7:0];
            end
            S_CCMD: begin eng_start = free; eng_byte = OPC_COL_CHANGE; end
            S_CONF: begin eng_start = free; eng_byte = is_prog ? OPC_PROG_CONF : OPC_ERASE_CONF; end
            S_SCMD: begin eng_start = free; eng_byte = OPC_STATUS; end
            S_SRD:  begin eng_start = free; eng_kind = CYC_RD; end
            default: ;
        endcase
    end

    // Sequence state, address shifter, guard timer and status capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            is_prog  <= 1'b0;
            cs_q     <= '0;
            adr_sr   <= '0;
            adr_left <= '0;
            wait_q   <= 1'b0;
            gcnt     <= '0;
            status_q <= '0;
        end else begin
            if (eng_start)     wait_q <= 1'b1;
            else if (eng_done) wait_q <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    is_prog  <= req_op;
                    cs_q     <= req_cs;
                    adr_sr   <= req_op ? {req_row, req_col} : {{COL_W{1'b0}}, req_row};
                    adr_left <= req_op ? LEFT_W'(ROW_BYTES + COL_BYTES) : LEFT_W'(ROW_BYTES);
                    st       <= S_CMD;
                end
                S_CMD:  if (eng_done) st <= S_ADR;
                S_ADR:  if (eng_done) begin
                    adr_sr   <= adr_sr >> 8;
                    adr_left <= adr_left - 1'b1;
                    if (adr_left == LEFT_W'(1)) st <= is_prog ? S_STRM : S_CONF;
                end
                S_STRM: if (wr_fire) begin
                    if (wr_kind == WK_COLCHG) begin
                        adr_sr   <= {{ROW_W{1'b0}}, wr_data};
                        adr_left <= LEFT_W'(COL_BYTES);
                        st       <= S_CCMD;
                    end else if (wr_kind == WK_END) begin
                        st <= S_CONF;
                    end
                end
                S_CCMD: if (eng_done) st <= S_ADR;
                S_CONF: if (eng_done) begin
                    gcnt <= G_W'(GUARD_CYC - 1);
                    st   <= S_GUARD;
                end
                S_GUARD: begin
                    if (gcnt == '0) st <= S_RB;
                    else            gcnt <= gcnt - 1'b1;
                end
                S_RB:   if (rb_ready) st <= S_SCMD;
                S_SCMD: if (eng_done) st <= S_SRD;
                S_SRD:  if (eng_done) begin
                    status_q <= eng_rd;
                    st       <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Request handshake, chip enables and result presentation
    always_comb begin
        req_ready = (st == S_IDLE);
        ce_n      = (st == S_IDLE) ? {NCE{1'b1}} : ~(NCE'(1) << cs_q);
        done      = (st == S_DONE);
        status    = status_q;
        fail      = status_q[0];
    end
endmodule

// File: rtl/nand_op_seq.sv
// Top: NAND operation sequencer. It joins the operation controller and the
// bus cycle engine and synchronises the asynchronous ready/busy input.
// Assumes an external pull-up on rb_n.
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int NCE       = 4,
    parameter int ROW_BYTES = 3,
    parameter int COL_BYTES = 2,
    parameter int T_LO      = 2,
    parameter int T_HI      = 2,
    parameter int GUARD_CYC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_op,
    input  logic [$clog2(NCE)-1:0] req_cs,
    input  logic [ROW_BYTES*8-1:0] req_row,
    input  logic [COL_BYTES*8-1:0] req_col,
    input  logic                   wr_valid,
    output logic                   wr_ready,
    input  logic [1:0]             wr_kind,
    input  logic [COL_BYTES*8-1:0] wr_data,
    output logic [NCE-1:0]         ce_n,
    output logic                   cle,
    output logic                   ale,
    output logic                   we_n,
    output logic                   re_n,
    output logic [7:0]             dq_out,
    output logic                   dq_oe,
    input  logic [7:0]             dq_in,
    input  logic                   rb_n,
    output logic                   done,
    output logic [7:0]             status,
    output logic                   fail
);
    logic [1:0] rb_sync;
    logic       eng_start, eng_busy, eng_done;
    cyc_kind_t  eng_kind;
    logic [7:0] eng_byte, eng_rd;

    // Two-stage synchroniser for the open-drain ready/busy line
    always_ff @(posedge clk) begin
        if (!rst_n) rb_sync <= 2'b00;
        else        rb_sync <= {rb_sync[0], rb_n};
    end

    nand_op_ctrl #(
        .NCE(NCE), .ROW_BYTES(ROW_BYTES), .COL_BYTES(COL_BYTES), .GUARD_CYC(GUARD_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_cs(req_cs), .req_row(req_row), .req_col(req_col),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind), .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rd(eng_rd),
        .rb_ready(rb_sync[1]),
        .eng_start(eng_start), .eng_kind(eng_kind), .eng_byte(eng_byte),
        .ce_n(ce_n), .done(done), .status(status), .fail(fail)
    );

    nand_cyc_engine #(.T_LO(T_LO), .T_HI(T_HI)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .kind(eng_kind), .wbyte(eng_byte), .dq_in(dq_in),
        .busy(eng_busy), .cyc_done(eng_done), .rd_byte(eng_rd),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/nand_op_seq_chk.sv
// Checker: protocol properties of the sequencer's bus pins, bound to the top.
module nand_op_seq_chk #(
    parameter int NCE = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCE-1:0] ce_n,
    input logic           cle,
    input logic           ale,
    input logic           we_n,
    input logic           re_n,
    input logic [7:0]     dq_out,
    input logic           dq_oe,
    input logic           done,
    input logic           req_ready
);
    assert_one_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_n) <= 1);
    assert_idle_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&ce_n));
    assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    assert_byte_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> $stable(dq_out));
    assert_write_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);
    assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!dq_oe && we_n && !cle && !ale));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind nand_op_seq nand_op_seq_chk #(.NCE(NCE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .done(done), .req_ready(req_ready)
);

// File: tb/nand_op_seq_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected bus cycles, filled by driver tasks and drained
// by a monitor at each rising WE# edge; models the device's busy time.
module nand_op_seq_bench;
    localparam int T_LO = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_op = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  dq_in = '0;
    logic        rb_n = 1'b1;
    logic        req_ready, wr_ready, cle, ale, we_n, re_n, dq_oe, done, fail;
    logic [3:0]  ce_n;
    logic [7:0]  dq_out, status;

    int checks = 0, errors = 0;
    logic [9:0] exp_q[$];
    logic [1:0] exp_cs = '0;
    logic [7:0] exp_status = '0;
    string      cur_req = "R1";
    logic       conf_seen = 1'b0, rb_released = 1'b0, done_seen = 1'b0;
    int         re_count = 0, low_cnt = 0;
    logic       prev_we = 1'b1, prev_re = 1'b1;

    always #10 clk = ~clk;

    nand_op_seq u_nand_op_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_cs(req_cs), .req_row(req_row), .req_col(req_col),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind), .wr_data(wr_data),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n),
        .done(done), .status(status), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic c, input logic a, input logic [7:0] b);
        exp_q.push_back({c, a, b});
    endtask

    task automatic start_op(input logic op, input logic [1:0] cs, input logic [23:0] row,
                            input logic [15:0] col, input logic [7:0] st, input string tag);
        cur_req = tag; exp_cs = cs; exp_status = st; dq_in = st;
        re_count = 0; rb_released = 1'b0;
        push(1, 0, op ? 8'h80 : 8'h60);
        if (op) begin push(0, 1, col[7:0]); push(0, 1, col[15:8]); end
        push(0, 1, row[7:0]); push(0, 1, row[15:8]); push(0, 1, row[23:16]);
        if (!op) push(1, 0, 8'hD0);
        @(negedge clk);
        req_op = op; req_cs = cs; req_row = row; req_col = col; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_item(input logic [1:0] kind, input logic [15:0] data);
        if (kind == 2'd0) push(0, 0, data[7:0]);
        else if (kind == 2'd1) begin push(1, 0, 8'h85); push(0, 1, data[7:0]); push(0, 1, data[15:8]); end
        else if (kind == 2'd2) push(1, 0, 8'h10);
        wr_kind = kind; wr_data = data; wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        push(1, 0, 8'h70);
        while (!done_seen) @(negedge clk);
        done_seen = 1'b0;
        @(negedge clk);
        chk(ce_n == 4'hF, "R5 ce idle after done", ce_n, 4'hF);
    endtask

    // Monitor: pops the scoreboard at each WE# rise and checks results at done
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (!we_n) low_cnt++;
            if (we_n && !prev_we) begin
                logic [9:0] got, exp;
                got = {cle, ale, dq_out};
                exp = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h3FF;
                chk(got == exp, {cur_req, " bus cycle (R4 cle/ale)"}, got, exp);
                chk(low_cnt == T_LO, "R4 WE# low width", low_cnt, T_LO);
                chk(dq_oe, "R8 dq_oe during write", dq_oe, 1);
                chk(ce_n == ~(4'b1 << exp_cs), "R5 selected ce_n", ce_n, ~(4'b1 << exp_cs));
                if (cle && (dq_out == 8'h10 || dq_out == 8'hD0)) conf_seen = 1'b1;
                low_cnt = 0;
            end
            if (re_n && !prev_re) begin
                re_count++;
                chk(!dq_oe, "R8 dq_oe released on read", dq_oe, 0);
            end
            if (done) begin
                chk(status == exp_status, "R7 status byte", status, exp_status);
                chk(fail == exp_status[0], "R7 fail flag", fail, exp_status[0]);
                chk(re_count == 1, "R7 single RE pulse", re_count, 1);
                chk(rb_released, "R6 done after ready", rb_released, 1);
                chk(exp_q.size() == 0, {cur_req, " all cycles sent"}, exp_q.size(), 0);
                done_seen = 1'b1;
            end
            prev_we = we_n; prev_re = re_n;
        end
    end

    // Device busy model: pulls ready/busy low shortly after a confirm command
    initial begin
        forever begin
            @(negedge clk);
            if (conf_seen) begin
                conf_seen = 1'b0;
                repeat (2) @(negedge clk);
                rb_n = 1'b0;
                repeat (20) @(negedge clk);
                rb_n = 1'b1;
                rb_released = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R7 watchdog: done act=0 exp=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n == 4'hF, "R9 reset ce_n", ce_n, 4'hF);
        chk(we_n && re_n, "R9 reset strobes", {we_n, re_n}, 2'b11);
        chk(!dq_oe && !done, "R9 reset oe/done", {dq_oe, done}, 0);
        chk(req_ready, "R9 reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: erase with non-zero page bits in the row
        start_op(1'b0, 2'd0, 24'h12347F, 16'h0, 8'h00, "R1");
        wait_done();

        // R2: plain program
        start_op(1'b1, 2'd2, 24'h000140, 16'h0800, 8'h00, "R2");
        send_item(2'd0, 16'h00AA);
        send_item(2'd0, 16'h0055);
        send_item(2'd0, 16'h000F);
        send_item(2'd2, 16'h0);
        wait_done();

        // R3: program with two column changes and a discarded item
        start_op(1'b1, 2'd3, 24'h0A0B0C, 16'h0010, 8'hC0, "R3");
        send_item(2'd0, 16'h0011);
        send_item(2'd1, 16'h0200);
        send_item(2'd0, 16'h0022);
        send_item(2'd3, 16'h00EE);
        send_item(2'd0, 16'h0033);
        send_item(2'd1, 16'h0301);
        send_item(2'd0, 16'h0044);
        send_item(2'd2, 16'h0);
        wait_done();

        // R7: erase that reports failure through status bit 0
        start_op(1'b0, 2'd1, 24'hFFFFFF, 16'h0, 8'h01, "R1");
        wait_done();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end
endmodule